// File: doc/BRIEF.md
# Two-Master Fixed-Priority Bus Arbiter

This block decides which of two masters owns a shared system bus: a processor core, which has the lower priority, and a data-transfer engine, which has the higher priority. Each master raises its own request line. The arbiter answers with a grant line to exactly one master, and that master keeps the bus for as long as its grant stays high. When no one asks for the bus, it stays parked with its last owner, and the processor owns it after reset.

A higher-priority request never takes the bus in the middle of an operation. The processor gives the bus up only at the end of one of its bus cycles, and not between the pieces of a split access such as a longword moved in two halves. The exception is a sleeping processor, which hands over at once. The transfer engine gives the bus back only at points it marks itself. It marks the end of a vector fetch, of a descriptor read, of one data move and of a descriptor write-back. It never marks the three states of a descriptor read or write-back, or the middle of a data move. All bus-cycle timing and engine sequencing come in as status inputs. Every grant change takes effect on the clock edge after the qualifying condition is sampled.

Top module: `busarb_duo`

## Requirements
- R1: While reset is held and after it is released, proc_gnt is 1 and xfer_gnt is 0 until a handover condition of R3, R5 or R7 is sampled.
- R2: In every cycle, exactly one of proc_gnt and xfer_gnt is high.
- R3: When the processor owns the bus and xfer_req, cyc_done and not span_lock are sampled together on a clock edge, xfer_gnt is high after that edge. This holds whatever the level of proc_req, so the transfer engine wins when both request.
- R4: When the processor owns the bus, is not asleep and xfer_req is high, the grant stays with the processor on every edge where cyc_done is low or span_lock is high. A cycle end that falls inside a locked split access is ignored.
- R5: When the processor owns the bus and proc_sleep and xfer_req are sampled high together, xfer_gnt is high after that edge, whatever cyc_done and span_lock are.
- R6: When the transfer engine owns the bus, it keeps the grant on every edge where xfer_rel_ok is low or xfer_req is high, even while proc_req is high.
- R7: When the transfer engine owns the bus and xfer_rel_ok is high, xfer_req is low and proc_req is high on a clock edge, proc_gnt is high after that edge.
- R8: When the transfer engine owns the bus and neither master requests, the grant stays parked with the transfer engine.
- R9: When the processor owns the bus and xfer_req is low, the grant stays with the processor whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| proc_req | input | 1 | Processor requests the bus |
| xfer_req | input | 1 | Transfer engine requests the bus |
| cyc_done | input | 1 | One-cycle pulse at the end of a bus cycle |
| span_lock | input | 1 | High while a split access still has pieces to run |
| proc_sleep | input | 1 | Processor is in sleep mode |
| xfer_rel_ok | input | 1 | Transfer engine is at a point where it may give up the bus |
| proc_gnt | output | 1 | Bus granted to the processor |
| xfer_gnt | output | 1 | Bus granted to the transfer engine |

## Verification
The hardest cases to reach are the ones where all six inputs act at once on a given owner. Examples are a cycle end that lands inside a locked split access while the processor sleeps, or a release point that comes while the engine still requests. Which rule applies depends on the owner at that moment. To cover these, the stimulus first steers the grant to the owner it wants, using only the ports. It then applies each of the 64 input combinations against that owner and predicts the outcome from the rules. A long pseudo-random run follows, which reaches handovers from arbitrary histories.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic {
    OWNER_PROC = 1'b0,
    OWNER_XFER = 1'b1
  } owner_t;

  // Processor-held bus may move to the engine: sleep bypass, or an
  // unlocked cycle break, and only when the engine wants the bus.
  function automatic logic proc_yields(input logic xreq, input logic cyc,
                                       input logic lock, input logic sleep);
    return xreq & (sleep | (cyc & ~lock));
  endfunction

  // Engine-held bus returns when the engine marks a release point, no
  // longer asks, and the processor is waiting.
  function automatic logic xfer_yields(input logic xreq, input logic rel,
                                       input logic preq);
    return rel & ~xreq & preq;
  endfunction

endpackage

// File: rtl/busarb_break_qual.sv
module busarb_break_qual
  import busarb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  owner_t owner,
  input  logic   proc_req,
  input  logic   xfer_req,
  input  logic   cyc_done,
  input  logic   span_lock,
  input  logic   proc_sleep,
  input  logic   xfer_rel_ok,
  output logic   take_fwd,
  output logic   give_back
);

  logic fwd_ok;
  logic back_ok;

  always_comb begin
    fwd_ok    = proc_yields(xfer_req, cyc_done, span_lock, proc_sleep);
    back_ok   = xfer_yields(xfer_req, xfer_rel_ok, proc_req);
    take_fwd  = (owner == OWNER_PROC) && fwd_ok;
    give_back = (owner == OWNER_XFER) && back_ok;
  end

  AST_QUAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_fwd && give_back)); // R2

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (span_lock && !proc_sleep) |-> !take_fwd); // R4

endmodule

// File: rtl/busarb_owner_reg.sv
module busarb_owner_reg
  import busarb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take_fwd,
  input  logic   give_back,
  output owner_t owner
);

  owner_t owner_nxt;

  always_comb begin
    owner_nxt = owner;
    if (take_fwd)       owner_nxt = OWNER_XFER;
    else if (give_back) owner_nxt = OWNER_PROC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWNER_PROC;
    else        owner <= owner_nxt;
  end

  AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_fwd && !give_back) |=> $stable(owner)); // R6

endmodule

// File: rtl/busarb_ack_decode.sv
module busarb_ack_decode
  import busarb_pkg::*;
(
  input  owner_t owner,
  output logic   proc_gnt,
  output logic   xfer_gnt
);

  always_comb begin
    proc_gnt = (owner == OWNER_PROC);
    xfer_gnt = (owner == OWNER_XFER);
  end

endmodule

// File: rtl/busarb_duo.sv
module busarb_duo
  import busarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic proc_req,
  input  logic xfer_req,
  input  logic cyc_done,
  input  logic span_lock,
  input  logic proc_sleep,
  input  logic xfer_rel_ok,
  output logic proc_gnt,
  output logic xfer_gnt
);

  owner_t owner;
  logic   take_fwd;
  logic   give_back;

  busarb_break_qual u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .owner      (owner),
    .proc_req   (proc_req),
    .xfer_req   (xfer_req),
    .cyc_done   (cyc_done),
    .span_lock  (span_lock),
    .proc_sleep (proc_sleep),
    .xfer_rel_ok(xfer_rel_ok),
    .take_fwd   (take_fwd),
    .give_back  (give_back)
  );

  busarb_owner_reg u_owner (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_fwd (take_fwd),
    .give_back(give_back),
    .owner    (owner)
  );

  busarb_ack_decode u_dec (
    .owner   (owner),
    .proc_gnt(proc_gnt),
    .xfer_gnt(xfer_gnt)
  );

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({proc_gnt, xfer_gnt}) == 1); // R2

  AST_BREAK_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_gnt && xfer_req && cyc_done && !span_lock) |=> xfer_gnt); // R3

  AST_NO_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_gnt && !proc_sleep && (!cyc_done || span_lock)) |=> proc_gnt); // R4

  AST_SLEEP_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_gnt && proc_sleep && xfer_req) |=> xfer_gnt); // R5

  AST_XFER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_gnt && (!xfer_rel_ok || xfer_req)) |=> xfer_gnt); // R6

  AST_XFER_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_gnt && xfer_rel_ok && !xfer_req && proc_req) |=> proc_gnt); // R7

  AST_XFER_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_gnt && !xfer_req && !proc_req) |=> xfer_gnt); // R8

  AST_PROC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_gnt && !xfer_req) |=> proc_gnt); // R9

endmodule

// File: tb/busarb_duo_test.sv
module busarb_duo_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proc_req = 1'b0, xfer_req = 1'b0, cyc_done = 1'b0;
  logic span_lock = 1'b0, proc_sleep = 1'b0, xfer_rel_ok = 1'b0;
  logic proc_gnt, xfer_gnt;

  int total = 0;
  int bad = 0;
  logic exp_x = 1'b0;   // bench's own idea of who owns: 1 = engine
  logic done = 1'b0;

  always #2 clk = ~clk;

  busarb_duo uut (
    .clk(clk), .rst_n(rst_n),
    .proc_req(proc_req), .xfer_req(xfer_req), .cyc_done(cyc_done),
    .span_lock(span_lock), .proc_sleep(proc_sleep), .xfer_rel_ok(xfer_rel_ok),
    .proc_gnt(proc_gnt), .xfer_gnt(xfer_gnt)
  );

  // bit map of a stimulus word:
  // 0 proc_req, 1 xfer_req, 2 cyc_done, 3 span_lock, 4 proc_sleep, 5 xfer_rel_ok
  function automatic logic predict(input logic own_x, input logic [5:0] v);
    logic pr, xr, cd, lk, sl, ok;
    {ok, sl, lk, cd, xr, pr} = v;
    if (!own_x) begin
      if (!xr) return 1'b0;
      if (sl)  return 1'b1;
      return cd && !lk;
    end
    if (xr || !ok || !pr) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string rule_of(input logic own_x, input logic [5:0] v);
    logic pr, xr, cd, lk, sl, ok;
    {ok, sl, lk, cd, xr, pr} = v;
    if (!own_x) begin
      if (!xr) return "R9";
      if (sl)  return "R5";
      if (cd && !lk) return "R3";
      return "R4";
    end
    if (ok && !xr && pr) return "R7";
    if (!xr && !pr) return "R8";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: grants {proc,xfer} actual=%b expected=%b", tag, got, want);
    end
  endtask

  // drive at posedge+1, sample at next posedge+1
  task automatic apply(input logic [5:0] v);
    logic nx;
    string tag;
    {xfer_rel_ok, proc_sleep, span_lock, cyc_done, xfer_req, proc_req} = v;
    nx  = predict(exp_x, v);
    tag = rule_of(exp_x, v);
    @(posedge clk);
    #1;
    exp_x = nx;
    check(tag, {proc_gnt, xfer_gnt}, {~exp_x, exp_x});
    check("R2", {1'b0, proc_gnt ^ xfer_gnt}, 2'b01);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {proc_gnt, xfer_gnt}, 2'b10);   // R1 during reset
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", {proc_gnt, xfer_gnt}, 2'b10);   // R1 after release, idle inputs
    exp_x = 1'b0;

    // sweep every input word against each owner
    for (int own = 0; own < 2; own++) begin
      for (int c = 0; c < 64; c++) begin
        if (own == 0) apply(6'b100001);  // release point with proc waiting -> proc (R7/R9)
        else          apply(6'b010010);  // sleep bypass -> engine (R5)
        apply(c[5:0]);
      end
    end

    // long mixed run from arbitrary histories
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[5:0] ^ lfsr[11:6]);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule